// File: doc/BRIEF.md
# OSD Dot Compositor

This block decides what one on-screen-display dot looks like. For each dot it receives a 3x3 window of font pixel bits centred on the dot, the 16-bit attribute word of the character cell the dot belongs to, the dot's position inside the cell, and the index of the text row. From these it produces a registered symbolic level code, a fill colour and a half-tone flag. The analog stage downstream turns these into video levels.

Per-cell processing covers blink, inverse and a one-dot 3-D box bevel. Per-row blanking can be none, character, outline or raster. A screen-wide blank override applies to every dot that is not a character dot. Blink timing comes from a field-rate tick. The period is selectable as one second or half a second, and the on-time duty is selectable.

Top module: `osd_dot_compositor`

## Requirements
- R1: After reset, out_valid is 0, out_level is VIDEO (0), out_rgb is 0 and out_half is 0.
- R2: A dot presented with dot_valid=1 appears on the outputs at the next clock edge, and out_valid follows dot_valid with one cycle of delay. While dot_valid=0, out_level, out_rgb and out_half hold their values.
- R3: Level codes are VIDEO=0, CHAR=1, FILL=2, EDGE=3, BOX_DARK=4 and BOX_LIGHT=5. The window bit glyph_win[4] is the dot itself, and glyph_win[r*3+c] is row r, column c. A set centre bit (after inverse and blink) gives CHAR, which has the highest priority.
- R4: Attribute layout: [15] box_inv, [14:13] box select, [12:10] background R,G,B, [9] invert, [8] blink, [7:0] character code. When invert=1, all nine window bits are complemented before any other step.
- R5: The blink phase counts field ticks modulo the period. The period is FIELD_RATE fields when blink_fast=0 and FIELD_RATE/2 fields when blink_fast=1. In the off phase, a cell with blink=1 shows no glyph: its window is all zero, even when invert=1. blink_duty=00 disables blinking.
- R6: blink_duty values 01, 10 and 11 give an on-phase of the first floor(P*k/4) fields of the period P, where k is the duty value.
- R7: A box select other than 00 draws a bevel one dot wide. With box_inv=0, the near edges (x=0 or y=0) are BOX_DARK and the far edges (x=CELL_W-1 or y=CELL_H-1) are BOX_LIGHT. box_inv=1 swaps the two. A near edge wins at a corner.
- R8: When the selected row's row_blank_sel bit is 1, blank_mode applies to dots that are not char dots and not box edges. Mode 00 changes nothing. Mode 01 gives FILL when the character code is non-zero. Mode 10 gives EDGE when any of the 8 neighbour bits is set. Mode 11 gives FILL.
- R9: all_blank=1 gives FILL to every non-CHAR dot, overriding the box bevel and row blanking.
- R10: out_half is 1 exactly when halftone_en=1 and the level is VIDEO.
- R11: out_rgb carries the cell background colour for FILL and is 0 for every other level.
- R12: A row_idx of ROWS or more is treated as a row whose blank bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_tick | input | 1 | One pulse per video field |
| blink_fast | input | 1 | 1 = half-second blink period |
| blink_duty | input | 2 | Blink on-time select |
| halftone_en | input | 1 | Half-luminance background |
| blank_mode | input | 2 | Global blank style |
| all_blank | input | 1 | Screen-wide blank override |
| row_blank_sel | input | ROWS | Blank enable per text row |
| row_idx | input | RW | Current text row |
| dot_valid | input | 1 | Dot inputs are valid |
| cell_attr | input | 16 | Cell attribute word |
| glyph_win | input | 9 | 3x3 font pixel window |
| dot_x | input | XW | Dot column in cell |
| dot_y | input | YW | Dot line in cell |
| out_valid | output | 1 | Output dot valid |
| out_level | output | 3 | Level code |
| out_rgb | output | 3 | Fill colour |
| out_half | output | 1 | Half-tone flag |

## Verification
The hardest state to reach is a blink phase boundary. Its position depends on how many field ticks have passed since reset, and that count is visible only through whether a blinking glyph shows. The bench never pulses field_tick before the blink scenario, so the phase is known to be zero. It then pulses exact tick counts to land on the last on-field, the first off-field and the wrap for each duty. It also switches the period between the full and half settings mid-count.

// File: rtl/osd_comp_pkg.sv
package osd_comp_pkg;

  typedef enum logic [2:0] {
    LV_VIDEO     = 3'd0,
    LV_CHAR      = 3'd1,
    LV_FILL      = 3'd2,
    LV_EDGE      = 3'd3,
    LV_BOX_DARK  = 3'd4,
    LV_BOX_LIGHT = 3'd5
  } lvl_e;

  typedef enum logic [1:0] {
    BM_NONE    = 2'd0,
    BM_CHAR    = 2'd1,
    BM_OUTLINE = 2'd2,
    BM_RASTER  = 2'd3
  } blank_mode_e;

  typedef struct packed {
    logic       box_inv;
    logic [1:0] box_sel;
    logic [2:0] bg_rgb;
    logic       invert;
    logic       blink;
    logic [7:0] code;
  } cell_attr_t;

  localparam int WIN_CENTER = 4;

  // Fields in one blink period.
  function automatic int blink_period_f(int rate, logic fast);
    return fast ? rate / 2 : rate;
  endfunction

  // Fields of the on-phase for a duty code of 1..3 (quarters).
  function automatic int blink_on_len_f(int period, int duty);
    return (period * duty) / 4;
  endfunction

endpackage

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int FIELD_RATE = 60,
  localparam int PHW = $clog2(FIELD_RATE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           field_tick,
  input  logic           fast,
  input  logic [1:0]     duty,
  output logic [PHW-1:0] phase,
  output logic           visible
);
  import osd_comp_pkg::*;

  logic [PHW-1:0] phase_q;
  int             per_i;
  int             on_i;

  always_comb begin
    per_i = blink_period_f(FIELD_RATE, fast);
    on_i  = blink_on_len_f(per_i, int'(duty));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (field_tick) begin
      if (int'(phase_q) + 1 >= per_i) phase_q <= '0;
      else                            phase_q <= phase_q + PHW'(1);
    end
  end

  assign phase   = phase_q;
  assign visible = (duty == 2'b00) || (int'(phase_q) < on_i);

endmodule

// File: rtl/osd_glyph_window.sv
module osd_glyph_window (
  input  logic [8:0] win_in,
  input  logic       invert,
  input  logic       hide,
  output logic [8:0] win_out,
  output logic       center,
  output logic       any_nbr
);
  import osd_comp_pkg::*;

  logic [8:0] inv_w;
  logic [8:0] nbr_mask;

  always_comb begin
    nbr_mask             = '1;
    nbr_mask[WIN_CENTER] = 1'b0;
  end

  genvar gi;
  generate
    for (gi = 0; gi < 9; gi++) begin : g_bit
      assign inv_w[gi]   = win_in[gi] ^ invert;
      assign win_out[gi] = inv_w[gi] & ~hide;
    end
  endgenerate

  assign center  = win_out[WIN_CENTER];
  assign any_nbr = |(win_out & nbr_mask);

endmodule

// File: rtl/osd_box_edge.sv
module osd_box_edge #(
  parameter int CELL_W = 12,
  parameter int CELL_H = 18,
  localparam int XW = $clog2(CELL_W),
  localparam int YW = $clog2(CELL_H)
) (
  input  logic [1:0]    box_sel,
  input  logic          box_inv,
  input  logic [XW-1:0] dot_x,
  input  logic [YW-1:0] dot_y,
  output logic          hit,
  output logic          dark
);
  localparam logic [XW-1:0] X_LAST = XW'(CELL_W - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(CELL_H - 1);

  logic near_edge;
  logic far_edge;

  assign near_edge = (dot_x == '0) || (dot_y == '0);
  assign far_edge  = (dot_x == X_LAST) || (dot_y == Y_LAST);
  assign hit       = (box_sel != 2'b00) && (near_edge || far_edge);
  assign dark      = near_edge ? ~box_inv : box_inv;

endmodule

// File: rtl/osd_dot_compositor.sv
module osd_dot_compositor #(
  parameter int FIELD_RATE = 60,
  parameter int ROWS       = 12,
  parameter int CELL_W     = 12,
  parameter int CELL_H     = 18,
  localparam int RW  = $clog2(ROWS),
  localparam int XW  = $clog2(CELL_W),
  localparam int YW  = $clog2(CELL_H),
  localparam int PHW = $clog2(FIELD_RATE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            field_tick,
  input  logic            blink_fast,
  input  logic [1:0]      blink_duty,
  input  logic            halftone_en,
  input  logic [1:0]      blank_mode,
  input  logic            all_blank,
  input  logic [ROWS-1:0] row_blank_sel,
  input  logic [RW-1:0]   row_idx,
  input  logic            dot_valid,
  input  logic [15:0]     cell_attr,
  input  logic [8:0]      glyph_win,
  input  logic [XW-1:0]   dot_x,
  input  logic [YW-1:0]   dot_y,
  output logic            out_valid,
  output logic [2:0]      out_level,
  output logic [2:0]      out_rgb,
  output logic            out_half
);
  import osd_comp_pkg::*;

  localparam int RPAD = 1 << RW;

  cell_attr_t     attr;
  logic [PHW-1:0] blink_phase;
  logic           blink_visible;
  logic           blink_hide;
  logic [8:0]     win_eff;
  logic           glyph_center;
  logic           glyph_any_nbr;
  logic           box_hit;
  logic           box_dark;
  logic [RPAD-1:0] row_pad;
  logic           row_blank_on;
  lvl_e           lvl_d;
  logic [2:0]     rgb_d;
  logic           half_d;

  assign attr       = cell_attr_t'(cell_attr);
  assign blink_hide = attr.blink & ~blink_visible;

  osd_blink_timer #(.FIELD_RATE(FIELD_RATE)) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_tick (field_tick),
    .fast       (blink_fast),
    .duty       (blink_duty),
    .phase      (blink_phase),
    .visible    (blink_visible)
  );

  osd_glyph_window u_win (
    .win_in  (glyph_win),
    .invert  (attr.invert),
    .hide    (blink_hide),
    .win_out (win_eff),
    .center  (glyph_center),
    .any_nbr (glyph_any_nbr)
  );

  osd_box_edge #(.CELL_W(CELL_W), .CELL_H(CELL_H)) u_box (
    .box_sel (attr.box_sel),
    .box_inv (attr.box_inv),
    .dot_x   (dot_x),
    .dot_y   (dot_y),
    .hit     (box_hit),
    .dark    (box_dark)
  );

  generate
    if (RPAD > ROWS) begin : g_row_pad
      assign row_pad = {{(RPAD - ROWS){1'b0}}, row_blank_sel};
    end else begin : g_row_exact
      assign row_pad = row_blank_sel;
    end
  endgenerate

  assign row_blank_on = row_pad[row_idx];

  always_comb begin
    lvl_d = LV_VIDEO;
    rgb_d = 3'b000;
    if (glyph_center) begin
      lvl_d = LV_CHAR;
    end else if (all_blank) begin
      lvl_d = LV_FILL;
      rgb_d = attr.bg_rgb;
    end else if (box_hit) begin
      lvl_d = box_dark ? LV_BOX_DARK : LV_BOX_LIGHT;
    end else if (row_blank_on) begin
      unique case (blank_mode_e'(blank_mode))
        BM_CHAR: begin
          if (attr.code != 8'h00) begin
            lvl_d = LV_FILL;
            rgb_d = attr.bg_rgb;
          end
        end
        BM_OUTLINE: begin
          if (glyph_any_nbr) lvl_d = LV_EDGE;
        end
        BM_RASTER: begin
          lvl_d = LV_FILL;
          rgb_d = attr.bg_rgb;
        end
        default: lvl_d = LV_VIDEO;
      endcase
    end
    half_d = halftone_en && (lvl_d == LV_VIDEO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_level <= LV_VIDEO;
      out_rgb   <= 3'b000;
      out_half  <= 1'b0;
    end else begin
      out_valid <= dot_valid;
      if (dot_valid) begin
        out_level <= lvl_d;
        out_rgb   <= rgb_d;
        out_half  <= half_d;
      end
    end
  end

  logic unused_win;
  assign unused_win = ^win_eff;

endmodule

// File: rtl/osd_comp_checker.sv
module osd_comp_checker #(
  parameter int FIELD_RATE = 60,
  parameter int PHW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dot_valid,
  input logic           all_blank,
  input logic [1:0]     blink_duty,
  input logic [15:0]    cell_attr,
  input logic           glyph_center,
  input logic           blink_visible,
  input logic [PHW-1:0] blink_phase,
  input logic           out_valid,
  input logic [2:0]     out_level,
  input logic [2:0]     out_rgb,
  input logic           out_half
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) dot_valid |=> out_valid); // R2
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !dot_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !dot_valid |=> $stable(out_level)); // R2
  AST_CHAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (dot_valid && glyph_center) |=> (out_level == 3'd1)); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) int'(blink_phase) < FIELD_RATE); // R5
  AST_DUTY_OFF_SHOWN: assert property (@(posedge clk) disable iff (!rst_n) (blink_duty == 2'b00) |-> blink_visible); // R5
  AST_BLINK_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n) (dot_valid && cell_attr[8] && !blink_visible) |=> (out_level != 3'd1)); // R5
  AST_ALL_BLANK_FILL: assert property (@(posedge clk) disable iff (!rst_n) (dot_valid && all_blank && !glyph_center) |=> (out_level == 3'd2 && out_rgb == $past(cell_attr[12:10]))); // R9
  AST_HALF_VIDEO_ONLY: assert property (@(posedge clk) disable iff (!rst_n) out_half |-> (out_level == 3'd0)); // R10
  AST_RGB_FILL_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (out_level != 3'd2) |-> (out_rgb == 3'b000)); // R11
endmodule

bind osd_dot_compositor osd_comp_checker #(.FIELD_RATE(FIELD_RATE), .PHW(PHW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dot_valid     (dot_valid),
  .all_blank     (all_blank),
  .blink_duty    (blink_duty),
  .cell_attr     (cell_attr),
  .glyph_center  (glyph_center),
  .blink_visible (blink_visible),
  .blink_phase   (blink_phase),
  .out_valid     (out_valid),
  .out_level     (out_level),
  .out_rgb       (out_rgb),
  .out_half      (out_half)
);

// File: tb/test_osd_dot_compositor.sv
module test_osd_dot_compositor;
  localparam logic [2:0] VID = 3'd0, CHR = 3'd1, FIL = 3'd2, EDG = 3'd3, BDK = 3'd4, BLT = 3'd5;
  localparam logic [8:0] W_CTR = 9'b000010000;
  localparam logic [8:0] W_NBR = 9'b000000001;
  localparam logic [8:0] W_NONE = 9'b000000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_tick = 1'b0;
  logic blink_fast = 1'b0;
  logic [1:0] blink_duty = 2'b00;
  logic halftone_en = 1'b0;
  logic [1:0] blank_mode = 2'b00;
  logic all_blank = 1'b0;
  logic [11:0] row_blank_sel = '0;
  logic [3:0] row_idx = '0;
  logic dot_valid = 1'b0;
  logic [15:0] cell_attr = '0;
  logic [8:0] glyph_win = '0;
  logic [3:0] dot_x = '0;
  logic [4:0] dot_y = '0;
  logic out_valid;
  logic [2:0] out_level;
  logic [2:0] out_rgb;
  logic out_half;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  osd_dot_compositor i_osd_dot_compositor (
    .clk(clk), .rst_n(rst_n), .field_tick(field_tick), .blink_fast(blink_fast),
    .blink_duty(blink_duty), .halftone_en(halftone_en), .blank_mode(blank_mode),
    .all_blank(all_blank), .row_blank_sel(row_blank_sel), .row_idx(row_idx),
    .dot_valid(dot_valid), .cell_attr(cell_attr), .glyph_win(glyph_win),
    .dot_x(dot_x), .dot_y(dot_y), .out_valid(out_valid), .out_level(out_level),
    .out_rgb(out_rgb), .out_half(out_half)
  );

  function automatic logic [15:0] mk_attr(logic binv, logic [1:0] bsel, logic [2:0] rgb,
                                          logic inv, logic blk, logic [7:0] code);
    return {binv, bsel, rgb, inv, blk, code};
  endfunction

  task automatic expect_out(string req, logic v, logic [2:0] lvl, logic [2:0] rgb, logic half);
    checks++;
    if (out_valid !== v || out_level !== lvl || out_rgb !== rgb || out_half !== half) begin
      errors++;
      $display("FAIL %s: got valid=%0b level=%0d rgb=%0d half=%0b, expected valid=%0b level=%0d rgb=%0d half=%0b",
               req, out_valid, out_level, out_rgb, out_half, v, lvl, rgb, half);
    end
  endtask

  // Present one dot at a falling edge, sample after the next rising edge.
  task automatic dot(logic [15:0] attr, logic [8:0] win, int x, int y);
    @(negedge clk);
    dot_valid = 1'b1;
    cell_attr = attr;
    glyph_win = win;
    dot_x = 4'(x);
    dot_y = 5'(y);
    @(negedge clk);
    dot_valid = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      field_tick = 1'b1;
      @(negedge clk);
      field_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    expect_out("R1 reset state", 1'b0, VID, 3'd0, 1'b0);
  endtask

  task automatic t_latency;
    dot(mk_attr(0, 2'b00, 3'd0, 0, 0, 8'h00), W_CTR, 5, 5);
    expect_out("R2 one-cycle latency", 1'b1, CHR, 3'd0, 1'b0);
    @(negedge clk);
    cell_attr = mk_attr(0, 2'b00, 3'd7, 0, 0, 8'h00);
    glyph_win = W_NONE;
    all_blank = 1'b1;
    @(negedge clk);
    expect_out("R2 hold while idle", 1'b0, CHR, 3'd0, 1'b0);
    all_blank = 1'b0;
  endtask

  task automatic t_char_inverse;
    dot(mk_attr(0, 2'b00, 3'd2, 0, 0, 8'h41), W_NONE, 5, 5);
    expect_out("R3 empty dot is video", 1'b1, VID, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd2, 1, 0, 8'h41), W_NONE, 5, 5);
    expect_out("R4 inverse makes char", 1'b1, CHR, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd2, 1, 0, 8'h41), W_CTR, 5, 5);
    expect_out("R4 inverse clears char", 1'b1, VID, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b01, 3'd2, 0, 0, 8'h41), W_CTR, 0, 0);
    expect_out("R3 char over box edge", 1'b1, CHR, 3'd0, 1'b0);
  endtask

  task automatic t_box;
    dot(mk_attr(0, 2'b01, 3'd5, 0, 0, 8'h00), W_NONE, 0, 5);
    expect_out("R7 sunken left dark", 1'b1, BDK, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b10, 3'd5, 0, 0, 8'h00), W_NONE, 11, 5);
    expect_out("R7 sunken right light", 1'b1, BLT, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b11, 3'd5, 0, 0, 8'h00), W_NONE, 5, 17);
    expect_out("R7 sunken bottom light", 1'b1, BLT, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b01, 3'd5, 0, 0, 8'h00), W_NONE, 11, 0);
    expect_out("R7 corner near wins", 1'b1, BDK, 3'd0, 1'b0);
    dot(mk_attr(1, 2'b01, 3'd5, 0, 0, 8'h00), W_NONE, 0, 3);
    expect_out("R7 raised left light", 1'b1, BLT, 3'd0, 1'b0);
    dot(mk_attr(1, 2'b01, 3'd5, 0, 0, 8'h00), W_NONE, 4, 17);
    expect_out("R7 raised bottom dark", 1'b1, BDK, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd5, 0, 0, 8'h00), W_NONE, 0, 0);
    expect_out("R7 box off", 1'b1, VID, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b01, 3'd5, 0, 0, 8'h00), W_NONE, 5, 5);
    expect_out("R7 interior untouched", 1'b1, VID, 3'd0, 1'b0);
  endtask

  task automatic t_row_blank;
    row_blank_sel = 12'b0000_0000_0100;
    row_idx = 4'd2;
    blank_mode = 2'b11;
    dot(mk_attr(0, 2'b00, 3'd3, 0, 0, 8'h00), W_NONE, 5, 5);
    expect_out("R8 raster fill, R11 colour", 1'b1, FIL, 3'd3, 1'b0);
    row_idx = 4'd3;
    dot(mk_attr(0, 2'b00, 3'd3, 0, 0, 8'h00), W_NONE, 5, 5);
    expect_out("R8 unselected row", 1'b1, VID, 3'd0, 1'b0);
    row_idx = 4'd2;
    dot(mk_attr(0, 2'b01, 3'd3, 0, 0, 8'h00), W_NONE, 0, 5);
    expect_out("R8 box over raster", 1'b1, BDK, 3'd0, 1'b0);
    blank_mode = 2'b01;
    dot(mk_attr(0, 2'b00, 3'd6, 0, 0, 8'h00), W_NONE, 5, 5);
    expect_out("R8 char blank code zero", 1'b1, VID, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd6, 0, 0, 8'h41), W_NONE, 5, 5);
    expect_out("R8 char blank code set", 1'b1, FIL, 3'd6, 1'b0);
    blank_mode = 2'b10;
    dot(mk_attr(0, 2'b00, 3'd6, 0, 0, 8'h41), W_NBR, 5, 5);
    expect_out("R8 outline next to glyph", 1'b1, EDG, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd6, 0, 0, 8'h41), W_NONE, 5, 5);
    expect_out("R8 outline far from glyph", 1'b1, VID, 3'd0, 1'b0);
    blank_mode = 2'b00;
    dot(mk_attr(0, 2'b00, 3'd6, 0, 0, 8'h41), W_NBR, 5, 5);
    expect_out("R8 mode none", 1'b1, VID, 3'd0, 1'b0);
    row_blank_sel = 12'hFFF;
    row_idx = 4'd13;
    blank_mode = 2'b11;
    dot(mk_attr(0, 2'b00, 3'd6, 0, 0, 8'h41), W_NONE, 5, 5);
    expect_out("R12 row index out of range", 1'b1, VID, 3'd0, 1'b0);
    row_blank_sel = '0;
    row_idx = 4'd0;
    blank_mode = 2'b00;
  endtask

  task automatic t_all_blank;
    all_blank = 1'b1;
    dot(mk_attr(0, 2'b01, 3'd4, 0, 0, 8'h00), W_NONE, 0, 0);
    expect_out("R9 all blank over box", 1'b1, FIL, 3'd4, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd4, 0, 0, 8'h00), W_CTR, 5, 5);
    expect_out("R9 char survives all blank", 1'b1, CHR, 3'd0, 1'b0);
    all_blank = 1'b0;
  endtask

  task automatic t_halftone;
    halftone_en = 1'b1;
    dot(mk_attr(0, 2'b00, 3'd1, 0, 0, 8'h00), W_NONE, 5, 5);
    expect_out("R10 half on video", 1'b1, VID, 3'd0, 1'b1);
    dot(mk_attr(0, 2'b00, 3'd1, 0, 0, 8'h00), W_CTR, 5, 5);
    expect_out("R10 no half on char", 1'b1, CHR, 3'd0, 1'b0);
    all_blank = 1'b1;
    dot(mk_attr(0, 2'b00, 3'd1, 0, 0, 8'h00), W_NONE, 5, 5);
    expect_out("R10 no half on fill", 1'b1, FIL, 3'd1, 1'b0);
    all_blank = 1'b0;
    halftone_en = 1'b0;
  endtask

  task automatic t_blink;
    logic [15:0] ba;
    ba = mk_attr(0, 2'b00, 3'd0, 0, 1, 8'h41);
    blink_fast = 1'b0;
    blink_duty = 2'b01;   // P=60, on 15 fields
    dot(ba, W_CTR, 5, 5);
    expect_out("R5 phase 0 shown", 1'b1, CHR, 3'd0, 1'b0);
    ticks(14);
    dot(ba, W_CTR, 5, 5);
    expect_out("R6 25% last on field", 1'b1, CHR, 3'd0, 1'b0);
    ticks(1);
    dot(ba, W_CTR, 5, 5);
    expect_out("R6 25% first off field", 1'b1, VID, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd0, 1, 1, 8'h41), W_NONE, 5, 5);
    expect_out("R5 inverse blinked off", 1'b1, VID, 3'd0, 1'b0);
    dot(mk_attr(0, 2'b00, 3'd0, 0, 0, 8'h41), W_CTR, 5, 5);
    expect_out("R5 non-blink cell steady", 1'b1, CHR, 3'd0, 1'b0);
    ticks(45);
    dot(ba, W_CTR, 5, 5);
    expect_out("R5 full period wrap", 1'b1, CHR, 3'd0, 1'b0);
    ticks(20);
    blink_duty = 2'b00;
    dot(ba, W_CTR, 5, 5);
    expect_out("R5 duty off no blink", 1'b1, CHR, 3'd0, 1'b0);
    blink_fast = 1'b1;
    blink_duty = 2'b11;   // P=30, on 22 fields; phase 20
    dot(ba, W_CTR, 5, 5);
    expect_out("R6 75% on at 20", 1'b1, CHR, 3'd0, 1'b0);
    ticks(2);
    dot(ba, W_CTR, 5, 5);
    expect_out("R6 75% off at 22", 1'b1, VID, 3'd0, 1'b0);
    ticks(7);
    dot(ba, W_CTR, 5, 5);
    expect_out("R5 half period last field", 1'b1, VID, 3'd0, 1'b0);
    ticks(1);
    dot(ba, W_CTR, 5, 5);
    expect_out("R5 half period wrap", 1'b1, CHR, 3'd0, 1'b0);
    blink_fast = 1'b0;
    blink_duty = 2'b10;   // P=60, on 30 fields
    ticks(29);
    dot(ba, W_CTR, 5, 5);
    expect_out("R6 50% last on field", 1'b1, CHR, 3'd0, 1'b0);
    ticks(1);
    dot(ba, W_CTR, 5, 5);
    expect_out("R6 50% first off field", 1'b1, VID, 3'd0, 1'b0);
    blink_duty = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_latency();
    t_char_inverse();
    t_box();
    t_row_blank();
    t_all_blank();
    t_halftone();
    t_blink();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected end within 100000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule